// File: doc/BRIEF.md
# Frame-Locked Calibration Pulse Scheduler

This block drives one logic line that switches a calibration noise source on and off. Its timing is tied to a wide frame counter that the signal-processing chain shares, so every on/off edge falls on a known frame count and not on a wall-clock tick. Software writes a future start count, a repeat period and an on-length, all in frame-counter units, and then sets the enable bit.

When enabled, the block compares the running frame counter with the start count. On a match it raises its output for the programmed number of counts. It then raises the output again every period after that start. The start count is wider than one write word, so it is written in two parts. Only the write of the upper part makes the new value active, which means a half-written value can never cause a match. All target compares are exact equality. The frame counter is expected to advance by at most one count per clock.

Top module: `calsrc_pulse_ctrl`

## Requirements
- R1: After reset, `pulse_out` is 0 and the block is disabled.
- R2: Register select codes on `wr_sel` when `wr_en` is 1: 0 is control, with bit 0 as enable. 1 is start bits [31:0]. 2 is start bits [47:32], taken from `wr_data[15:0]`. 3 is the period. 4 is the on-length. While enable is 0, `pulse_out` is 0 whatever the frame counter does.
- R3: Once enabled, `pulse_out` rises in the cycle after the one in which `frame_cnt` equals the start count.
- R4: `pulse_out` stays high for exactly on-length frame counts. It drops in the cycle after `frame_cnt` equals start plus on-length.
- R5: The high window repeats at start plus k times the period, for k = 1, 2, and so on.
- R6: A write to the low start half alone does not change the active start count. A write to the high half makes both halves active together.
- R7: If the on-length is non-zero and not less than the period, `pulse_out` stays high without a break once the start is reached.
- R8: A control write that clears enable forces `pulse_out` to 0 in the cycle after the write. A later enable waits for the start count again.
- R9: The start compare is equality only. A start count that the counter has already passed does not fire until the counter wraps around and reaches it.
- R10: An on-length of 0 keeps `pulse_out` at 0.
- R11: All target arithmetic wraps modulo 2^48, so windows that cross the counter's wrap point keep their spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_cnt | input | 48 | Shared frame counter |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select code |
| wr_data | input | 32 | Register write data |
| pulse_out | output | 1 | Noise-source switch line |

## Verification
The bench builds the block with its default widths: a 48-bit counter, a 32-bit low start half, and 32-bit period and on-length. It drives `frame_cnt` directly, so it can jump the counter to within a few counts of 2^48 and step it across the wrap point. Cases that a free-running counter would only reach after days therefore take a few dozen cycles. Cases that exercise both start halves, and starts whose windows straddle the wrap point, run at full width.

// File: rtl/calsrc_pkg.sv
package calsrc_pkg;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_CTRL     = 3'd0;
  localparam logic [SEL_W-1:0] SEL_START_LO = 3'd1;
  localparam logic [SEL_W-1:0] SEL_START_HI = 3'd2;
  localparam logic [SEL_W-1:0] SEL_PERIOD   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_ONLEN    = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ON    = 2'd2,
    ST_SOLID = 2'd3
  } calsrc_state_e;
endpackage

// File: rtl/calsrc_regs.sv
module calsrc_regs
  import calsrc_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int DATA_W = 32,
  parameter int LO_W   = 32,
  parameter int PER_W  = 32,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              en_next_o,
  output logic [CNT_W-1:0]  start_o,
  output logic [PER_W-1:0]  period_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int HI_W = CNT_W - LO_W;

  logic              en_q, en_d;
  logic [LO_W-1:0]   shadow_q, shadow_d;
  logic [CNT_W-1:0]  start_q, start_d;
  logic [PER_W-1:0]  period_q, period_d;
  logic [LEN_W-1:0]  len_q, len_d;

  always_comb begin
    en_d     = en_q;
    shadow_d = shadow_q;
    start_d  = start_q;
    period_d = period_q;
    len_d    = len_q;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_CTRL:     en_d     = wr_data[0];
        SEL_START_LO: shadow_d = wr_data[LO_W-1:0];
        SEL_START_HI: start_d  = {wr_data[HI_W-1:0], shadow_q};
        SEL_PERIOD:   period_d = wr_data[PER_W-1:0];
        SEL_ONLEN:    len_d    = wr_data[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      shadow_q <= '0;
      start_q  <= '0;
      period_q <= '0;
      len_q    <= '0;
    end else if (wr_en) begin
      en_q     <= en_d;
      shadow_q <= shadow_d;
      start_q  <= start_d;
      period_q <= period_d;
      len_q    <= len_d;
    end
  end

  assign en_next_o = en_d;
  assign start_o   = start_q;
  assign period_o  = period_q;
  assign len_o     = len_q;

  // R6: a low-half write alone leaves the active start untouched
  assert_lo_half_atomic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_START_LO) |=> $stable(start_o));
endmodule

// File: rtl/calsrc_eq.sv
module calsrc_eq #(
  parameter int W     = 48,
  parameter int SLICE = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);
  localparam int NSL = (W + SLICE - 1) / SLICE;

  logic [NSL-1:0] hit;

  for (genvar g = 0; g < NSL; g++) begin : g_slice
    localparam int LO = g * SLICE;
    localparam int HI = (LO + SLICE > W) ? W - 1 : LO + SLICE - 1;
    assign hit[g] = (a[HI:LO] == b[HI:LO]);
  end

  assign eq = &hit;
endmodule

// File: rtl/calsrc_seq.sv
module calsrc_seq
  import calsrc_pkg::*;
#(
  parameter int CNT_W    = 48,
  parameter int PER_W    = 32,
  parameter int LEN_W    = 32,
  parameter int EQ_SLICE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] start,
  input  logic [PER_W-1:0] period,
  input  logic [LEN_W-1:0] len,
  input  logic [CNT_W-1:0] frame_cnt,
  output logic             pulse_o
);
  calsrc_state_e    state_q, state_d;
  logic [CNT_W-1:0] tgt_on_q, tgt_on_d;
  logic [CNT_W-1:0] tgt_off_q, tgt_off_d;
  logic             pulse_q, pulse_d;

  logic [CNT_W-1:0] cmp_target;
  logic [CNT_W-1:0] period_x, len_x;
  logic             hit_on, hit_off;
  logic             len_zero, len_covers;

  assign cmp_target = (state_q == ST_IDLE) ? start : tgt_on_q;
  assign period_x   = CNT_W'(period);
  assign len_x      = CNT_W'(len);
  assign len_zero   = (len == '0);
  assign len_covers = (len_x >= period_x);

  calsrc_eq #(.W(CNT_W), .SLICE(EQ_SLICE)) u_eq_on (
    .a (frame_cnt),
    .b (cmp_target),
    .eq(hit_on)
  );

  calsrc_eq #(.W(CNT_W), .SLICE(EQ_SLICE)) u_eq_off (
    .a (frame_cnt),
    .b (tgt_off_q),
    .eq(hit_off)
  );

  always_comb begin
    state_d   = state_q;
    tgt_on_d  = tgt_on_q;
    tgt_off_d = tgt_off_q;
    pulse_d   = pulse_q;
    if (!en) begin
      state_d = ST_IDLE;
      pulse_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_WAIT: begin
          if (hit_on) begin
            tgt_on_d  = cmp_target + period_x;
            tgt_off_d = cmp_target + len_x;
            if (len_zero) begin
              state_d = ST_WAIT;
              pulse_d = 1'b0;
            end else if (len_covers) begin
              state_d = ST_SOLID;
              pulse_d = 1'b1;
            end else begin
              state_d = ST_ON;
              pulse_d = 1'b1;
            end
          end else if (state_q == ST_IDLE) begin
            tgt_on_d = start;
            state_d  = ST_WAIT;
          end
        end
        ST_ON: begin
          if (hit_off) begin
            state_d = ST_WAIT;
            pulse_d = 1'b0;
          end
        end
        ST_SOLID: pulse_d = 1'b1;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tgt_on_q  <= '0;
      tgt_off_q <= '0;
      pulse_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      tgt_on_q  <= tgt_on_d;
      tgt_off_q <= tgt_off_d;
      pulse_q   <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;

  // R2: enable low forces the line low at the next edge
  assert_low_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en) |=> !pulse_o);

  // R3: every rising edge follows an exact counter match
  assert_rise_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> ($past(frame_cnt) == $past(cmp_target)));

  // R4: a fall while still enabled follows the end-of-window match
  assert_fall_on_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pulse_o) && $past(en)) |-> ($past(frame_cnt) == $past(tgt_off_q)));
endmodule

// File: rtl/calsrc_pulse_ctrl.sv
module calsrc_pulse_ctrl
  import calsrc_pkg::*;
#(
  parameter int CNT_W    = 48,
  parameter int DATA_W   = 32,
  parameter int LO_W     = 32,
  parameter int PER_W    = 32,
  parameter int LEN_W    = 32,
  parameter int EQ_SLICE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  frame_cnt,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pulse_out
);
  logic             en_next;
  logic [CNT_W-1:0] start;
  logic [PER_W-1:0] period;
  logic [LEN_W-1:0] len;

  calsrc_regs #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .LO_W(LO_W), .PER_W(PER_W), .LEN_W(LEN_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .en_next_o(en_next),
    .start_o  (start),
    .period_o (period),
    .len_o    (len)
  );

  calsrc_seq #(
    .CNT_W(CNT_W), .PER_W(PER_W), .LEN_W(LEN_W), .EQ_SLICE(EQ_SLICE)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_next),
    .start    (start),
    .period   (period),
    .len      (len),
    .frame_cnt(frame_cnt),
    .pulse_o  (pulse_out)
  );
endmodule

// File: tb/calsrc_pulse_ctrl_bench.sv
module calsrc_pulse_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic [47:0] frame_cnt;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic        pulse_out;

  int n_checks;
  int n_bad;

  logic        m_en, m_go;
  logic [47:0] m_s;
  logic [31:0] m_p, m_l;

  typedef struct packed {
    logic [47:0] s;
    logic [31:0] p;
    logic [31:0] l;
    logic [47:0] first;
    logic [15:0] n;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{s: 48'd100,             p: 32'd10, l: 32'd3, first: 48'd95,              n: 16'd40},
    '{s: 48'hFFFF_FFFF_FFF8,  p: 32'd6,  l: 32'd2, first: 48'hFFFF_FFFF_FFF6,  n: 16'd30},
    '{s: 48'd500,             p: 32'd5,  l: 32'd5, first: 48'd497,             n: 16'd20},
    '{s: 48'd1000,            p: 32'd8,  l: 32'd0, first: 48'd996,             n: 16'd20},
    '{s: 48'h0001_2345_6789,  p: 32'd16, l: 32'd7, first: 48'h0001_2345_6785,  n: 16'd40}
  };

  calsrc_pulse_ctrl u_calsrc_pulse_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_cnt(frame_cnt),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .pulse_out(pulse_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic model(input logic [47:0] c);
    logic [47:0] d;
    if (!m_en) return 1'b0;
    if (!m_go && c == m_s) m_go = 1'b1;
    if (!m_go) return 1'b0;
    if (m_l == 0) return 1'b0;
    if (m_l >= m_p) return 1'b1;
    d = c - m_s;
    return ((d % 48'(m_p)) < 48'(m_l));
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pulse_out=%0b expected=%0b cnt=%0d", tag, act, exp, frame_cnt);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input logic [47:0] c, input string tag);
    logic e;
    @(negedge clk);
    frame_cnt = c;
    @(posedge clk);
    #1;
    e = model(c);
    check(pulse_out, e, tag);
  endtask

  task automatic program_all(input logic [47:0] s, input logic [31:0] p,
                             input logic [31:0] l, input logic [47:0] c0);
    wr(3'd0, 32'd0);
    m_en = 1'b0;
    frame_cnt = c0;
    wr(3'd1, s[31:0]);
    wr(3'd2, {16'd0, s[47:32]});
    wr(3'd3, p);
    wr(3'd4, l);
    m_s = s; m_p = p; m_l = l; m_go = 1'b0;
    wr(3'd0, 32'd1);
    m_en = 1'b1;
  endtask

  initial begin
    n_checks = 0; n_bad = 0;
    m_en = 1'b0; m_go = 1'b0; m_s = '0; m_p = '0; m_l = '0;
    rst_n = 1'b0; frame_cnt = '0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check(pulse_out, 1'b0, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pulse_out, 1'b0, "R1");

    // table: R3 R4 R5 / R11 wrap / R7 solid / R10 zero length / R6 both halves
    for (int i = 0; i < 5; i++) begin
      string tag;
      case (i)
        0: tag = "R5";
        1: tag = "R11";
        2: tag = "R7";
        3: tag = "R10";
        default: tag = "R6";
      endcase
      program_all(VEC[i].s, VEC[i].p, VEC[i].l, VEC[i].first);
      for (int k = 0; k < int'(VEC[i].n); k++)
        step(VEC[i].first + 48'(k), tag);
    end

    // R2: disabled, counter passes programmed start
    wr(3'd0, 32'd0);
    m_en = 1'b0;
    frame_cnt = 48'd40;
    wr(3'd1, 32'd50);
    wr(3'd2, 32'd0);
    wr(3'd3, 32'd4);
    wr(3'd4, 32'd2);
    for (int k = 45; k < 70; k++) step(48'(k), "R2");

    // R6: low-half write alone must not move the active start
    program_all(48'd200, 32'd100, 32'd3, 48'd130);
    wr(3'd0, 32'd0);
    m_en = 1'b0;
    wr(3'd1, 32'd150);
    wr(3'd0, 32'd1);
    m_en = 1'b1; m_go = 1'b0;
    for (int k = 140; k < 210; k++) step(48'(k), "R6");
    wr(3'd0, 32'd0);
    m_en = 1'b0;
    frame_cnt = 48'd140;
    wr(3'd2, 32'd0);
    wr(3'd0, 32'd1);
    m_en = 1'b1; m_go = 1'b0; m_s = 48'd150;
    for (int k = 145; k < 160; k++) step(48'(k), "R6");

    // R3 start then R8 clear while high
    program_all(48'd300, 32'd10, 32'd5, 48'd296);
    for (int k = 298; k < 302; k++) step(48'(k), "R3");
    wr(3'd0, 32'd0);
    m_en = 1'b0;
    check(pulse_out, 1'b0, "R8");
    // R8/R9: re-enable past the start, no firing until wrap
    frame_cnt = 48'd305;
    wr(3'd0, 32'd1);
    m_en = 1'b1; m_go = 1'b0;
    for (int k = 306; k < 331; k++) step(48'(k), "R8");
    for (int k = 0; k < 4; k++) step(48'hFFFF_FFFF_FFFC + 48'(k), "R9");
    for (int k = 0; k < 316; k++) step(48'(k), "R9");

    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule